// File: doc/BRIEF.md
# Cascaded Boxcar Low-Pass Filter

This block smooths a stream of 14-bit signed samples with two moving-average stages in series. Each stage averages the most recent N = 2^m accepted samples. The two stages together give a triangular impulse response that spans 2N-1 input samples. A sample enters when `in_valid` is high. A filtered sample leaves with `out_valid` once both stages hold a full window.

The tap exponent m comes from `taps_cfg`. A measurement-range code on `range_cfg` sets a minimum that m is raised to. The narrower ranges need heavier averaging to keep their resolution. When the effective exponent changes, both stages drop their history and start filling again. A configuration change that leaves the effective exponent unchanged does not disturb the stream.

Top module: `bartlett_filter`

## Requirements
- R1: While reset is held and after it is released, `out_valid` stays low until enough samples have been accepted. The internal effective exponent starts at 2.
- R2: Each stage outputs floor(S / N), where S is the sum of its last N inputs and N = 2^m_eff. The floor rounds toward minus infinity.
- R3: After a history clear, the first valid output belongs to the (2N-1)-th accepted sample. No output appears before it.
- R4: Once the pipeline is full, every accepted sample yields exactly one output. That output is valid exactly two clock cycles after the input cycle.
- R5: The effective exponent is max(taps_cfg, floor). The floor is 4 for range code 3'b001, 2 for range code 3'b010, and 0 for code 3'b100 or any other code.
- R6: A change of the effective exponent clears both stages. Outputs then stay invalid until the 2N-1 samples of the new setting have arrived.
- R7: A change of `taps_cfg` or `range_cfg` that leaves the effective exponent unchanged keeps the history. The output sequence continues as if no change had occurred.
- R8: Full-scale input does not overflow at N = 128. A constant 8191 settles to 8191, and a constant -8192 settles to -8192.
- R9: Cycles with `in_valid` low produce no output and leave the filter state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| taps_cfg | input | 3 | Requested tap exponent m |
| range_cfg | input | 3 | Measurement-range code that sets the minimum exponent |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 14 | Input sample, two's complement |
| out_valid | output | 1 | Filtered sample strobe |
| out_data | output | 14 | Filtered sample, two's complement |

## Verification
The bench runs stimulus against a queue-based reference that knows the expected value and the arrival cycle of each output. It therefore catches a premature first output, a 2N or 2N-2 fill count, and a result that is a cycle late. It drives negative ramps and odd sums, so a design that truncates toward zero instead of flooring produces off-by-one values. Configuration changes during operation are tested in two ways. A real change of the effective exponent must clear the history, and a design that keeps stale history emits early, wrong outputs. A change that the floor absorbs must not clear, and a design that flushes anyway loses outputs. Full-scale constant streams at 128 taps expose a sum register that is too narrow. Idle gaps expose a design that shifts on invalid cycles.

// File: rtl/bartlett_pkg.sv
package bartlett_pkg;

  typedef enum logic [2:0] {
    RNG_NARROW = 3'b001,
    RNG_MID    = 3'b010,
    RNG_WIDE   = 3'b100
  } range_e;

  localparam int NARROW_FLOOR = 4;
  localparam int MID_FLOOR    = 2;
  localparam int RESET_LOG    = 2;

  // Minimum tap exponent demanded by a range code; unknown codes impose none.
  function automatic int range_floor(input logic [2:0] code);
    int fl;
    case (code)
      RNG_NARROW: fl = NARROW_FLOOR;
      RNG_MID:    fl = MID_FLOOR;
      default:    fl = 0;
    endcase
    return fl;
  endfunction

endpackage

// File: rtl/bartlett_tap_sel.sv
module bartlett_tap_sel
  import bartlett_pkg::*;
#(
  parameter int LOGW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LOGW-1:0] taps_cfg,
  input  logic [2:0]      range_cfg,
  output logic [LOGW-1:0] log_q,
  output logic            flush
);

  logic [LOGW-1:0] floor_v;
  logic [LOGW-1:0] eff_d;

  // Next-state: effective exponent and change detection.
  always_comb begin
    floor_v = LOGW'(range_floor(range_cfg));
    eff_d   = (taps_cfg < floor_v) ? floor_v : taps_cfg;
    flush   = (eff_d != log_q);
  end

  // Register with explicit enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_q <= LOGW'(RESET_LOG);
    end else if (flush) begin
      log_q <= eff_d;
    end
  end

  assert_narrow_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (range_cfg == RNG_NARROW) |=> (log_q >= LOGW'(NARROW_FLOOR)));

  assert_mid_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (range_cfg == RNG_MID) |=> (log_q >= LOGW'(MID_FLOOR)));

  assert_hold_setting_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> $stable(log_q));

endmodule

// File: rtl/bartlett_boxcar.sv
module bartlett_boxcar #(
  parameter int DATA_W = 14,
  parameter int LOGW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOGW-1:0]   log_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int MAX_LOG = (1 << LOGW) - 1;
  localparam int DEPTH   = 1 << MAX_LOG;
  localparam int AW      = MAX_LOG;
  localparam int CNT_W   = MAX_LOG + 1;
  localparam int SUM_W   = DATA_W + MAX_LOG + 1;

  logic [DATA_W-1:0]       hist [DEPTH];
  logic [AW-1:0]           wr_q, wr_d;
  logic [CNT_W-1:0]        fill_q, fill_d, fill_inc, taps;
  logic signed [SUM_W-1:0] sum_q, sum_d, sum_nxt, in_ext, old_ext;
  logic [AW-1:0]           old_idx;
  logic [DATA_W-1:0]       rd_word;
  logic                    full, wr_en;
  logic                    ov_d;
  logic [DATA_W-1:0]       od_d;
  logic signed [SUM_W-1:0] lim_hi, lim_lo, taps_s;

  // Next-state logic.
  always_comb begin
    taps     = CNT_W'(1) << log_n;
    full     = (fill_q == taps);
    fill_inc = fill_q + CNT_W'(1);
    old_idx  = wr_q - taps[AW-1:0];
    rd_word  = hist[old_idx];
    in_ext   = {{(SUM_W-DATA_W){in_data[DATA_W-1]}}, in_data};
    old_ext  = full ? {{(SUM_W-DATA_W){rd_word[DATA_W-1]}}, rd_word} : '0;
    sum_nxt  = sum_q + in_ext - old_ext;

    sum_d  = sum_q;
    fill_d = fill_q;
    wr_d   = wr_q;
    wr_en  = 1'b0;
    ov_d   = 1'b0;
    od_d   = out_data;
    if (flush) begin
      sum_d  = '0;
      fill_d = '0;
      wr_d   = '0;
    end else if (in_valid) begin
      sum_d  = sum_nxt;
      fill_d = full ? fill_q : fill_inc;
      wr_d   = wr_q + AW'(1);
      wr_en  = 1'b1;
      ov_d   = full || (fill_inc == taps);
      od_d   = DATA_W'(sum_nxt >>> log_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q     <= '0;
      fill_q    <= '0;
      wr_q      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      sum_q     <= sum_d;
      fill_q    <= fill_d;
      wr_q      <= wr_d;
      out_valid <= ov_d;
      out_data  <= od_d;
    end
  end

  // History storage: no reset, stale entries are masked by the fill count.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      hist[wr_q] <= in_data;
    end
  end

  always_comb begin
    taps_s = $signed({{(SUM_W-CNT_W){1'b0}}, taps});
    lim_hi = taps_s * $signed(SUM_W'((1 << (DATA_W-1)) - 1));
    lim_lo = -(taps_s <<< (DATA_W-1));
  end

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= taps);

  assert_valid_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (fill_q == taps));

  assert_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_flush_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill_q == '0) && !out_valid);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_q <= lim_hi) && (sum_q >= lim_lo));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !flush) |=> $stable(sum_q) && $stable(fill_q));

endmodule

// File: rtl/bartlett_filter.sv
module bartlett_filter #(
  parameter int DATA_W = 14,
  parameter int LOGW   = 3,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOGW-1:0]   taps_cfg,
  input  logic [2:0]        range_cfg,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic              rst_meta, rst_sync;
  logic [LOGW-1:0]   log_q;
  logic              flush;
  logic [STAGES:0]   v_chain;
  logic [DATA_W-1:0] d_chain [STAGES+1];

  // Reset: asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  bartlett_tap_sel #(.LOGW(LOGW)) u_tap_sel (
    .clk       (clk),
    .rst_n     (rst_sync),
    .taps_cfg  (taps_cfg),
    .range_cfg (range_cfg),
    .log_q     (log_q),
    .flush     (flush)
  );

  assign v_chain[0] = in_valid;
  assign d_chain[0] = in_data;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    bartlett_boxcar #(.DATA_W(DATA_W), .LOGW(LOGW)) u_box (
      .clk       (clk),
      .rst_n     (rst_sync),
      .log_n     (log_q),
      .flush     (flush),
      .in_valid  (v_chain[g]),
      .in_data   (d_chain[g]),
      .out_valid (v_chain[g+1]),
      .out_data  (d_chain[g+1])
    );
  end

  assign out_valid = v_chain[STAGES];
  assign out_data  = d_chain[STAGES];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync |=> !out_valid);

endmodule

// File: tb/bartlett_filter_test.sv
module bartlett_filter_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  taps_cfg;
  logic [2:0]  range_cfg;
  logic        in_valid;
  logic [13:0] in_data;
  logic        out_valid;
  logic [13:0] out_data;

  always #2 clk = ~clk;

  bartlett_filter uut (
    .clk(clk), .rst_n(rst_n), .taps_cfg(taps_cfg), .range_cfg(range_cfg),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  typedef struct { int val; longint cyc; string req; } exp_t;
  exp_t   expq[$];
  int     h1[$];
  int     h2[$];
  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  int     cur_eff = 2;
  bit     done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int eff_of(int m, logic [2:0] r);
    int fl;
    fl = (r == 3'b001) ? 4 : (r == 3'b010) ? 2 : 0;
    return (m < fl) ? fl : m;
  endfunction

  task automatic stage_push(ref int h[$], input int x, input int m,
                            output bit ok, output int y);
    int s;
    h.push_back(x);
    if (h.size() > (1 << m)) void'(h.pop_front());
    ok = (h.size() == (1 << m));
    s = 0;
    foreach (h[i]) s += h[i];
    y = s >>> m;
  endtask

  task automatic send(input int x, input string req);
    bit ok1, ok2;
    int y1, y2;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x[13:0];
    stage_push(h1, x, cur_eff, ok1, y1);
    if (ok1) begin
      stage_push(h2, y1, cur_eff, ok2, y2);
      if (ok2) expq.push_back('{y2, cyc + 2, req});
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic check_drained(input string req);
    idle(4);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d outputs missing (expected 0)", req, expq.size());
      expq.delete();
    end
  endtask

  task automatic set_cfg(input int m, input logic [2:0] r);
    int e;
    idle(4);
    taps_cfg  = m[2:0];
    range_cfg = r;
    e = eff_of(m, r);
    if (e != cur_eff) begin
      h1.delete();
      h2.delete();
      cur_eff = e;
    end
    @(negedge clk);
  endtask

  // Monitor: compare each output against the scoreboard head.
  always @(negedge clk) begin
    while (expq.size() > 0 && expq[0].cyc < cyc) begin
      checks++;
      fails++;
      $display("FAIL %s: output due at cycle %0d missing (actual none, expected %0d)",
               expq[0].req, expq[0].cyc, expq[0].val);
      void'(expq.pop_front());
    end
    if (out_valid === 1'b1) begin
      checks++;
      if (expq.size() == 0 || expq[0].cyc != cyc) begin
        fails++;
        $display("FAIL R3/R4/R9: unexpected output at cycle %0d (actual %0d, expected none)",
                 cyc, $signed(out_data));
      end else begin
        if ($signed(out_data) != expq[0].val) begin
          fails++;
          $display("FAIL %s: cycle %0d actual %0d expected %0d",
                   expq[0].req, cyc, $signed(out_data), expq[0].val);
        end
        void'(expq.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    taps_cfg = 3'd2; range_cfg = 3'b100;
    repeat (5) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: out_valid during reset actual %b expected 0", out_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: out_valid after reset actual %b expected 0", out_valid);
    end

    // R2 R3 R4: default N=4, negative-going ramp with odd sums
    for (int i = 0; i < 30; i++) send(5 - 3 * i, "R2");
    check_drained("R4");

    // R9: sparse stream with idle gaps
    for (int i = 0; i < 25; i++) begin
      send((i * 37) % 101 - 50, "R9");
      idle(i % 3);
    end
    check_drained("R9");

    // R5 / R7: mid range with m=0 keeps exponent 2, history kept
    set_cfg(0, 3'b010);
    for (int i = 0; i < 6; i++) send(-7 * i, "R7");
    check_drained("R7");

    // R5 / R6: narrow range raises m=1 to 4, clears
    set_cfg(1, 3'b001);
    for (int i = 0; i < 40; i++) send((i * 1234) % 8000 - 4000, "R5");
    check_drained("R5");

    // R7: m=3 under narrow range still 4, stream continues
    set_cfg(3, 3'b001);
    for (int i = 0; i < 12; i++) send(100 - i * 11, "R7");
    check_drained("R7");

    // R6: partial fill then real change to N=2
    set_cfg(1, 3'b100);
    for (int i = 0; i < 10; i++) send(i * i - 20, "R6");
    check_drained("R6");

    // R5: unknown range code imposes no floor (m=5)
    set_cfg(5, 3'b000);
    for (int i = 0; i < 80; i++) send((i * 577) % 3001 - 1500, "R5");
    check_drained("R5");

    // R8: full scale at N=128
    set_cfg(7, 3'b100);
    for (int i = 0; i < 300; i++) send(8191, "R8");
    for (int i = 0; i < 300; i++) send(-8192, "R8");
    for (int i = 0; i < 300; i++) send((i % 2) ? 8191 : -8192, "R8");
    check_drained("R8");

    // R2: pseudo-random stream at N=8
    set_cfg(3, 3'b100);
    for (int i = 0; i < 200; i++) send(int'($urandom_range(16383)) - 8192, "R2");
    check_drained("R2");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule